// File: doc/BRIEF.md
# Edge Interval Meter

The block measures the time between transitions of a single digital input in units of timebase ticks. A free-running counter of `CNT_W` bits advances once per cycle in which the tick enable is high. The meter latches that counter at the transition that opens a measurement and again at the transition that closes it, and it subtracts the two values. In period mode a measurement runs from one rising edge to the next, and each closing rising edge also opens the next measurement. In pulse mode a measurement runs from a rising edge to the falling edge that follows it.

A difference of only `CNT_W` bits is wrong for any interval that spans a counter wrap. The meter therefore counts the counter wraps that occur while a measurement is open, in an `OVF_W`-bit saturating counter. It reports the result as `(wraps << CNT_W) + end - start`, taken modulo 2^(CNT_W+OVF_W). With the default widths this is a 32-bit result from a 16-bit timebase, and the resolution is one tick. For example, one tick is 500 ns when the tick enable runs at 2 MHz.

Each result is a single-cycle strobe with data and an overrange flag. The output has no ready signal and applies no back-pressure: the consumer must take the result in the cycle in which `res_valid` is high. The data stays on the port until the next result replaces it.

Top module: `edge_interval_meter`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid`, `res_ticks` and `res_overrange` are all 0.
- R2: The timebase advances by one only in cycles where `tick_en` is 1, so a result counts enabled cycles and not clock cycles.
- R3: In period mode (`meas_mode` = 0) each result equals the number of ticks between two successive rising edges of `sig_in`.
- R4: In pulse mode (`meas_mode` = 1) each result equals the number of ticks from a rising edge to the next falling edge. The low time that follows is not measured, and the next measurement opens at the next rising edge.
- R5: A wrap of the timebase in the cycle of the opening edge, or in any later cycle before the closing edge, adds 2^CNT_W to the result. A wrap in the cycle of the closing edge does not. Intervals of 2^CNT_W ticks or more are therefore reported exactly.
- R6: `res_valid` is high for exactly one clock, in the cycle after the closing edge is sampled. The first rising edge after reset only opens a measurement and produces no result.
- R7: When the wrap count of a measurement reaches all ones (2^OVF_W - 1), it stops there and `res_overrange` is 1 with that result. The data is then computed with the saturated count.
- R8: `meas_mode` is sampled only when a measurement opens. A change while a measurement is open does not affect that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase advance enable, one tick per enabled cycle |
| sig_in | input | 1 | Signal under measurement, synchronous to `clk` |
| meas_mode | input | 1 | 0 = period, 1 = pulse width |
| res_valid | output | 1 | One-cycle result strobe |
| res_ticks | output | CNT_W+OVF_W | Measured interval in ticks |
| res_overrange | output | 1 | Wrap count saturated during this measurement |

## Verification
The bench drives square waves with short periods, periods beyond one timebase wrap, and intervals long enough to saturate the wrap count. These separate plain subtraction from wrap extension, and wrap extension from overrange. A gated tick enable shows whether ticks or clock cycles are counted. Pulse-mode waves with unequal high and low times show whether the high phase alone is measured. A mode change in the middle of a period measurement shows whether the mode is latched at the opening edge. Pseudo-random edge spacing places edges in the cycles where the counter wraps, which exercises the boundary rule for counting wraps.

// File: rtl/meter_pkg.sv
`timescale 1ns/1ps
package meter_pkg;
  typedef enum logic {
    MODE_PERIOD = 1'b0,
    MODE_PULSE  = 1'b1
  } meas_mode_e;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } meter_state_e;
endpackage

// File: rtl/tick_timebase.sv
`timescale 1ns/1ps
module tick_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (tick_en) count <= count + 1'b1;
  end

  // counter is at its top value and about to roll over
  assign wrap = tick_en & (&count);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (count == ($past(tick_en) ? CNT_W'($past(count) + 1'b1) : $past(count))));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));
endmodule

// File: rtl/edge_finder.sv
`timescale 1ns/1ps
module edge_finder (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
  assign fall = ~sig & sig_q;

  assert_rise_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/interval_ctrl.sv
`timescale 1ns/1ps
module interval_ctrl
  import meter_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       count,
  input  logic                   wrap,
  input  logic                   rise,
  input  logic                   fall,
  input  logic                   mode_in,
  output logic                   res_valid,
  output logic [CNT_W+OVF_W-1:0] res_ticks,
  output logic                   res_over
);
  localparam int RES_W = CNT_W + OVF_W;
  localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

  meter_state_e     state;
  meas_mode_e       mode_l;
  logic [CNT_W-1:0] start_q;
  logic [OVF_W-1:0] ovf_q;
  logic             start_evt;
  logic             end_evt;
  logic [OVF_W-1:0] ovf_next;
  logic [RES_W-1:0] span;

  // closing edge depends on the mode latched at the opening edge
  assign end_evt = (state == ST_RUN) &&
                   (((mode_l == MODE_PERIOD) && rise) ||
                    ((mode_l == MODE_PULSE)  && fall));
  // a rising edge opens a measurement when idle, or re-opens one in period mode
  assign start_evt = rise && ((state == ST_WAIT) || (mode_l == MODE_PERIOD));

  assign ovf_next = (wrap && (ovf_q != OVF_MAX)) ? ovf_q + 1'b1 : ovf_q;

  assign span = {ovf_q, {CNT_W{1'b0}}} + RES_W'(count) - RES_W'(start_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAIT;
      mode_l  <= MODE_PERIOD;
      start_q <= '0;
      ovf_q   <= '0;
    end else if (start_evt) begin
      state   <= ST_RUN;
      mode_l  <= meas_mode_e'(mode_in);
      start_q <= count;
      ovf_q   <= wrap ? OVF_W'(1) : '0;
    end else if (end_evt) begin
      state <= ST_WAIT;
    end else if (state == ST_RUN) begin
      ovf_q <= ovf_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ticks <= '0;
      res_over  <= 1'b0;
    end else begin
      res_valid <= end_evt;
      if (end_evt) begin
        res_ticks <= span;
        res_over  <= (ovf_q == OVF_MAX);
      end
    end
  end

  assert_valid_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(state) == ST_RUN));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN) && ($past(state) == ST_RUN) && !$past(start_evt))
      |-> (mode_l == $past(mode_l)));

  assert_ovf_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN) && ($past(state) == ST_RUN) && !$past(start_evt))
      |-> (ovf_q >= $past(ovf_q)));

  assert_over_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_over) |-> ($past(ovf_q) == OVF_MAX));
endmodule

// File: rtl/edge_interval_meter.sv
`timescale 1ns/1ps
module edge_interval_meter #(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16,
  localparam int RES_W = CNT_W + OVF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sig_in,
  input  logic             meas_mode,
  output logic             res_valid,
  output logic [RES_W-1:0] res_ticks,
  output logic             res_overrange
);
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             rise;
  logic             fall;

  tick_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count), .wrap(wrap)
  );

  edge_finder u_edges (
    .clk(clk), .rst_n(rst_n), .sig(sig_in), .rise(rise), .fall(fall)
  );

  interval_ctrl #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .count(count), .wrap(wrap),
    .rise(rise), .fall(fall), .mode_in(meas_mode),
    .res_valid(res_valid), .res_ticks(res_ticks), .res_over(res_overrange)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !res_valid);
endmodule

// File: tb/edge_interval_meter_bench.sv
`timescale 1ns/1ps
module edge_interval_meter_bench;
  localparam int C = 8;
  localparam int O = 4;
  localparam int R = C + O;
  localparam longint M = 64'd1 << C;
  localparam longint WMAX = (64'd1 << O) - 1;
  localparam longint MASK = (64'd1 << R) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic tick_en = 1;
  logic sig_in = 0;
  logic meas_mode = 0;
  logic res_valid;
  logic [R-1:0] res_ticks;
  logic res_overrange;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  edge_interval_meter #(.CNT_W(C), .OVF_W(O)) u_edge_interval_meter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sig_in(sig_in),
    .meas_mode(meas_mode), .res_valid(res_valid), .res_ticks(res_ticks),
    .res_overrange(res_overrange)
  );

  // behavioural reference: absolute tick time, no counter width
  longint ticks = 0, s_abs = 0;
  bit prev = 0, running = 0, md = 0;
  bit exp_v = 0, exp_o = 0, exp_md = 0, exp_long = 0;
  longint exp_d = 0;
  int model_n = 0, dut_n = 0;
  longint dut_last = 0;

  task automatic emit();
    longint wr, w;
    wr = ticks / M - s_abs / M;
    w = (wr > WMAX) ? WMAX : wr;
    exp_d = ((w << C) + (ticks % M) - (s_abs % M)) & MASK;
    exp_o = (wr >= WMAX);
    exp_md = md;
    exp_long = (ticks - s_abs) >= M;
    exp_v = 1;
    model_n++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ticks = 0; prev = 0; running = 0; exp_v = 0;
    end else begin
      bit rise, fall;
      rise = sig_in && !prev;
      fall = !sig_in && prev;
      exp_v = 0;
      if (!running) begin
        if (rise) begin s_abs = ticks; md = meas_mode; running = 1; end
      end else if (!md && rise) begin
        emit(); s_abs = ticks; md = meas_mode;
      end else if (md && fall) begin
        emit(); running = 0;
      end
      prev = sig_in;
      if (tick_en) ticks++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(res_valid == exp_v, "R6 valid strobe", res_valid, exp_v);
      if (exp_v && res_valid) begin
        dut_n++;
        dut_last = res_ticks;
        chk(res_ticks == exp_d[R-1:0],
            exp_long ? "R5 extended interval" : (exp_md ? "R4 pulse width" : "R3 period"),
            res_ticks, exp_d);
        chk(res_overrange == exp_o, "R7 overrange flag", res_overrange, exp_o);
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wave(input int hi, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      sig_in = 1; repeat (hi) @(negedge clk);
      sig_in = 0; repeat (lo) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int base;

  initial begin
    repeat (4) @(negedge clk);
    chk(res_valid == 0 && res_ticks == 0 && res_overrange == 0, "R1 reset outputs",
        {res_valid, res_overrange, res_ticks}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0 && res_ticks == 0, "R1 first cycle after reset", res_valid, 0);

    // period mode, short periods; first rise only arms
    base = dut_n;
    wave(5, 5, 5); idle(3);
    chk(dut_n - base == 4, "R6 first edge arms only", dut_n - base, 4);
    chk(dut_last == 10, "R3 period value", dut_last, 10);

    // period beyond one wrap
    wave(150, 150, 3); idle(3);
    chk(dut_last == 300, "R5 period over one wrap", dut_last, 300);
    wave(400, 600, 3); idle(3);
    chk(dut_last == 1000, "R5 period over several wraps", dut_last, 1000);

    // gated tick enable: every other cycle
    fork
      begin
        for (int k = 0; k < 200; k++) begin tick_en = ~tick_en; @(negedge clk); end
        tick_en = 1;
      end
      wave(20, 20, 4);
    join
    idle(3);
    chk(dut_last == 20, "R2 ticks counted not clocks", dut_last, 20);

    // pulse mode: mode is taken at the next opening rise
    meas_mode = 1;
    wave(7, 13, 5); idle(3);
    chk(dut_last == 7, "R4 pulse width high time only", dut_last, 7);
    wave(600, 5, 2); idle(3);
    chk(dut_last == 600, "R4 R5 long pulse", dut_last, 600);

    // overrange: 5000 ticks spans more than 15 wraps
    wave(5000, 10, 1); idle(3);
    chk(res_overrange == 1, "R7 overrange seen", res_overrange, 1);
    wave(9, 9, 1); idle(3);
    chk(res_overrange == 0 && dut_last == 9, "R7 overrange cleared next result", dut_last, 9);

    // mode change inside an open period measurement
    meas_mode = 0;
    wave(6, 6, 2);
    sig_in = 1; idle(4); meas_mode = 1; idle(4);
    sig_in = 0; idle(9);
    base = dut_n;
    sig_in = 1; idle(2);
    chk(dut_n - base == 1 && dut_last == 17, "R8 open measurement keeps period mode",
        dut_last, 17);
    idle(5); sig_in = 0; idle(3);
    chk(dut_last == 7, "R8 new measurement uses pulse mode", dut_last, 7);

    // pseudo-random spacing across wrap boundaries, both modes
    for (int m = 0; m < 2; m++) begin
      meas_mode = m[0];
      for (int k = 0; k < 60; k++)
        wave($urandom_range(1, 300), $urandom_range(1, 300), 1);
      idle(3);
    end
    chk(dut_n == model_n, "R6 result count matches", dut_n, model_n);

    summary();
    $finish;
  end
endmodule